// File: doc/BRIEF.md
# Locked-Antiphase H-Bridge Gate Driver

This block turns a signed control effort into the four gate enables of a full H-bridge. The effort, which arrives from a PI stage in the range -1024 to +1024, is shifted up by half a PWM period and clamped into a duty command between 0 and the full period. A free-running period counter, 2000 counts long at the default size (20 kHz from a 40 MHz clock), compares against that command. While the count is below the duty, the positive diagonal (leg A high side with leg B low side) is requested. For the rest of the period, the negative diagonal (leg B high side with leg A low side) is requested.

Both diagonals are switched in every period, so a duty of exactly half the period gives zero average armature voltage. A larger duty drives the motor in the positive direction and a smaller one drives it in the negative direction. Each time the request moves from one diagonal to the other, all four switches stay off for a programmable number of clock cycles before the new diagonal is turned on. Turn-off is immediate, so a diagonal whose share of the period is shorter than the dead-time never turns on in that period. The duty command is taken only at period boundaries. The gate enables are registered and are active high.

Top module: `hb_lap_driver`

## Requirements
- R1: The duty command is the signed effort plus OFFSET (default 1000), clamped to 0 when the sum is negative and to PERIOD (default 2000) when the sum exceeds PERIOD.
- R2: The period counter runs 0 to PERIOD-1 and wraps. The positive diagonal is requested while count < duty, and the negative diagonal is requested otherwise. Gate outputs follow the request with one register of latency.
- R3: The effort is sampled only on the clock edge on which the counter wraps from PERIOD-1 to 0. An effort change at any other point in a period has no effect on that period.
- R4: The pair a_hi_o/b_lo_o always carries the same value, and the pair b_hi_o/a_lo_o always carries the same value.
- R5: The high-side and low-side enables of the same leg are never both 1.
- R6: When the request changes diagonal, all four outputs are 0 for exactly dead_cycles_i cycles before the new diagonal turns on (dead_cycles_i held constant outside reset).
- R7: When 0 < duty < PERIOD, the positive diagonal is on for max(0, duty - dead) cycles per period, and the negative diagonal is on for max(0, PERIOD - duty - dead) cycles per period.
- R8: At duty 0, the negative diagonal stays on continuously. At duty PERIOD, the positive diagonal stays on continuously. In both cases there is no dead gap once the diagonal has settled.
- R9: A synchronous active-high reset forces all four outputs to 0 on the next edge, and it returns the counter to 0 and the duty command to OFFSET. The first period after reset therefore runs at zero average voltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| effort_i | input | EFF_W | Signed control effort (two's complement) |
| dead_cycles_i | input | DT_W | Dead-time length in clock cycles |
| a_hi_o | output | 1 | Leg A high-side enable (positive diagonal) |
| a_lo_o | output | 1 | Leg A low-side enable (negative diagonal) |
| b_hi_o | output | 1 | Leg B high-side enable (negative diagonal) |
| b_lo_o | output | 1 | Leg B low-side enable (positive diagonal) |

## Verification
The hardest case to reach is a diagonal whose share of the period is shorter than, or equal to, the dead-time, so that it must stay dark for a whole period while the other diagonal still gets its full delay. The bench reaches this case by sweeping every effort that maps across the full duty range, including both clamp limits and the extreme codes of the input width, at several dead-time settings up to the counter's saturation value, in a shortened 40-count period. Each effort is held for a span that is not a multiple of the period, so that changes land mid-period and test the boundary latch. A cycle-by-cycle reference and a per-period on-time count derived arithmetically from duty and dead-time are compared at the ports.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // Which diagonal of the bridge is currently requested
    typedef enum logic [1:0] {
        PAIR_NONE = 2'd0,
        PAIR_POS  = 2'd1,
        PAIR_NEG  = 2'd2
    } pair_e;

endpackage

// File: rtl/hb_period_ctr.sv
module hb_period_ctr #(
    parameter int PERIOD = 2000,
    parameter int CNT_W  = 11
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (ctr_q.cnt == LAST) begin
            ctr_d.cnt = '0;
        end else begin
            ctr_d.cnt = ctr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt_o  = ctr_q.cnt;
    assign wrap_o = (ctr_q.cnt == LAST);

endmodule

// File: rtl/hb_cmd_latch.sv
module hb_cmd_latch #(
    parameter int EFF_W  = 12,
    parameter int PERIOD = 2000,
    parameter int OFFSET = 1000,
    parameter int CNT_W  = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic signed [EFF_W-1:0] effort_i,
    output logic [CNT_W-1:0]        duty_o
);
    localparam int SUM_W = ((EFF_W > CNT_W) ? EFF_W : CNT_W) + 2;
    localparam logic signed [SUM_W-1:0] OFS_S = SUM_W'(OFFSET);
    localparam logic signed [SUM_W-1:0] TOP_S = SUM_W'(PERIOD);

    typedef struct packed {
        logic [CNT_W-1:0] duty;
    } cmd_t;

    cmd_t cmd_d, cmd_q;
    logic signed [SUM_W-1:0] shifted;
    logic [CNT_W-1:0]        clamped;

    always_comb begin
        shifted = SUM_W'(effort_i) + OFS_S;
        if (shifted < 0) begin
            clamped = '0;
        end else if (shifted > TOP_S) begin
            clamped = CNT_W'(PERIOD);
        end else begin
            clamped = shifted[CNT_W-1:0];
        end

        cmd_d = cmd_q;
        if (load_i) begin
            cmd_d.duty = clamped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q.duty <= CNT_W'(OFFSET);
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign duty_o = cmd_q.duty;

endmodule

// File: rtl/hb_deadband.sv
module hb_deadband
    import hb_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            want_pos_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            pos_on_o,
    output logic            neg_on_o
);
    localparam logic [DT_W-1:0] RUN_MAX = {DT_W{1'b1}};

    typedef struct packed {
        pair_e           last;
        logic [DT_W-1:0] run;
        logic            pos;
        logic            neg;
    } db_t;

    db_t db_d, db_q;
    pair_e req;

    always_comb begin
        req  = want_pos_i ? PAIR_POS : PAIR_NEG;
        db_d = db_q;

        // Age of the current request, restarted at every handover
        if (req != db_q.last) begin
            db_d.run = '0;
        end else if (db_q.run != RUN_MAX) begin
            db_d.run = db_q.run + 1'b1;
        end
        db_d.last = req;

        // Turn-on waits for the dead-time; turn-off is immediate
        db_d.pos = (req == PAIR_POS) && (db_d.run >= dead_i);
        db_d.neg = (req == PAIR_NEG) && (db_d.run >= dead_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            db_q.last <= PAIR_POS;
            db_q.run  <= '0;
            db_q.pos  <= 1'b0;
            db_q.neg  <= 1'b0;
        end else begin
            db_q <= db_d;
        end
    end

    assign pos_on_o = db_q.pos;
    assign neg_on_o = db_q.neg;

endmodule

// File: rtl/hb_lap_driver.sv
module hb_lap_driver #(
    parameter int PERIOD = 2000,
    parameter int OFFSET = 1000,
    parameter int EFF_W  = 12,
    parameter int DT_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [EFF_W-1:0] effort_i,
    input  logic [DT_W-1:0]         dead_cycles_i,
    output logic                    a_hi_o,
    output logic                    a_lo_o,
    output logic                    b_hi_o,
    output logic                    b_lo_o
);
    localparam int CNT_W = $clog2(PERIOD + 1);

    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] duty_w;
    logic             wrap_w;
    logic             want_pos;
    logic             pos_on;
    logic             neg_on;

    hb_period_ctr #(
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W)
    ) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt_w),
        .wrap_o (wrap_w)
    );

    hb_cmd_latch #(
        .EFF_W  (EFF_W),
        .PERIOD (PERIOD),
        .OFFSET (OFFSET),
        .CNT_W  (CNT_W)
    ) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .load_i   (wrap_w),
        .effort_i (effort_i),
        .duty_o   (duty_w)
    );

    assign want_pos = (cnt_w < duty_w);

    hb_deadband #(
        .DT_W (DT_W)
    ) u_db (
        .clk        (clk),
        .rst        (rst),
        .want_pos_i (want_pos),
        .dead_i     (dead_cycles_i),
        .pos_on_o   (pos_on),
        .neg_on_o   (neg_on)
    );

    // Diagonal pairs: A-high with B-low, B-high with A-low
    assign a_hi_o = pos_on;
    assign b_lo_o = pos_on;
    assign b_hi_o = neg_on;
    assign a_lo_o = neg_on;

endmodule

// File: rtl/hb_lap_checker.sv
module hb_lap_checker
    import hb_pkg::*;
#(
    parameter int PERIOD = 2000,
    parameter int CNT_W  = 11,
    parameter int DT_W   = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [DT_W-1:0]  dead,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] duty,
    input logic             a_hi,
    input logic             a_lo,
    input logic             b_hi,
    input logic             b_lo
);
    localparam logic [DT_W:0] OFF_MAX = {(DT_W + 1){1'b1}};

    pair_e         last_q;
    logic [DT_W:0] off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= PAIR_NONE;
            off_q  <= '0;
        end else if (a_hi) begin
            last_q <= PAIR_POS;
            off_q  <= '0;
        end else if (b_hi) begin
            last_q <= PAIR_NEG;
            off_q  <= '0;
        end else if (off_q != OFF_MAX) begin
            off_q <= off_q + 1'b1;
        end
    end

    p_duty_range_r1: assert property (@(posedge clk) disable iff (rst)
        duty <= CNT_W'(PERIOD));

    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_W'(PERIOD - 1)) |=> (cnt == '0));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt != CNT_W'(PERIOD - 1)) |=> (cnt == $past(cnt) + 1'b1));

    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> (duty == $past(duty)));

    p_diag_pair_r4: assert property (@(posedge clk) disable iff (rst)
        (a_hi == b_lo) && (b_hi == a_lo));

    p_leg_a_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(a_hi && a_lo));

    p_leg_b_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(b_hi && b_lo));

    p_gap_to_neg_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(b_hi) && (last_q == PAIR_POS)) |-> (off_q >= {1'b0, dead}));

    p_gap_to_pos_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(a_hi) && (last_q == PAIR_NEG)) |-> (off_q >= {1'b0, dead}));

    p_reset_off_r9: assert property (@(posedge clk)
        rst |=> !(a_hi || a_lo || b_hi || b_lo));

endmodule

bind hb_lap_driver hb_lap_checker #(
    .PERIOD (PERIOD),
    .CNT_W  (CNT_W),
    .DT_W   (DT_W)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .dead (dead_cycles_i),
    .cnt  (cnt_w),
    .duty (duty_w),
    .a_hi (a_hi_o),
    .a_lo (a_lo_o),
    .b_hi (b_hi_o),
    .b_lo (b_lo_o)
);

// File: tb/tb_hb_lap_driver.sv
module tb_hb_lap_driver;

    localparam int PER  = 40;
    localparam int OFS  = 20;
    localparam int EW   = 8;
    localparam int DW   = 4;
    localparam int HOLD = 125;
    localparam int WIN0 = 85;

    logic                 clk    = 1'b0;
    logic                 rst    = 1'b1;
    logic signed [EW-1:0] effort = '0;
    logic [DW-1:0]        dead   = '0;
    logic                 a_hi, a_lo, b_hi, b_lo;

    always #4 clk = ~clk;

    hb_lap_driver #(
        .PERIOD (PER),
        .OFFSET (OFS),
        .EFF_W  (EW),
        .DT_W   (DW)
    ) dut (
        .clk           (clk),
        .rst           (rst),
        .effort_i      (effort),
        .dead_cycles_i (dead),
        .a_hi_o        (a_hi),
        .a_lo_o        (a_lo),
        .b_hi_o        (b_hi),
        .b_lo_o        (b_lo)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Reference built from the requirements
    int m_cnt  = 0;
    int m_duty = OFS;
    int m_run  = 0;
    bit m_last = 1'b1;
    bit e_p    = 1'b0;
    bit e_n    = 1'b0;

    function automatic int clamp_duty(input int e);
        int s;
        s = e + OFS;
        if (s < 0) return 0;
        if (s > PER) return PER;
        return s;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt  = 0;
            m_duty = OFS;
            m_last = 1'b1;
            m_run  = 0;
            e_p    = 1'b0;
            e_n    = 1'b0;
        end else begin
            bit w;
            w = (m_cnt < m_duty);
            if (w != m_last) m_run = 0;
            else if (m_run < (1 << DW) - 1) m_run = m_run + 1;
            m_last = w;
            e_p = w && (m_run >= int'(dead));
            e_n = !w && (m_run >= int'(dead));
            if (m_cnt == PER - 1) begin
                m_cnt  = 0;
                m_duty = clamp_duty(int'(effort));
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: sample at the falling edge, compare against the reference
    task automatic cyc(output bit p, output bit n);
        int act;
        int exp;
        @(negedge clk);
        act = int'({a_hi, a_lo, b_hi, b_lo});
        exp = int'({e_p, e_n, e_n, e_p});
        // R2 R3 R6 R9 cycle timing, R4 diagonal pairing
        check(act == exp, "R2/R3/R6 cycle model", act, exp);
        // R5 leg exclusivity
        check(!(a_hi && a_lo) && !(b_hi && b_lo), "R5 leg overlap",
              int'({a_hi, a_lo, b_hi, b_lo}), 0);
        check((a_hi == b_lo) && (b_hi == a_lo), "R4 diagonal pairing",
              int'({a_hi, a_lo, b_hi, b_lo}), exp);
        p = a_hi;
        n = b_hi;
    endtask

    initial begin
        int dts[4];
        dts = '{0, 3, 7, 15};
        for (int i = 0; i < 4; i++) begin
            rst  = 1'b1;
            dead = DW'(dts[i]);
            for (int r = 0; r < 3; r++) begin
                @(negedge clk);
                check({a_hi, a_lo, b_hi, b_lo} == 4'b0000, "R9 reset outputs off",
                      int'({a_hi, a_lo, b_hi, b_lo}), 0);
            end
            rst = 1'b0;
            for (int k = -31; k <= 31; k++) begin
                int e, d, xp, xn, cp, cn;
                bit p, n;
                e = (k == -31) ? -128 : ((k == 31) ? 127 : k);
                effort = EW'(e);
                cp = 0;
                cn = 0;
                for (int c = 0; c < HOLD; c++) begin
                    cyc(p, n);
                    if (c >= WIN0 && c < WIN0 + PER) begin
                        cp += int'(p);
                        cn += int'(n);
                    end
                end
                d = clamp_duty(e);
                if (d == 0) begin
                    xp = 0;   xn = PER;   // R8 full negative
                end else if (d == PER) begin
                    xp = PER; xn = 0;     // R8 full positive
                end else begin
                    xp = (d - dts[i] > 0) ? d - dts[i] : 0;               // R7
                    xn = (PER - d - dts[i] > 0) ? PER - d - dts[i] : 0;   // R7
                end
                check(cp == xp, "R1/R7/R8 positive on-time", cp, xp);
                check(cn == xn, "R1/R7/R8 negative on-time", cn, xn);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule